// File: doc/BRIEF.md
# Prefixed Bit-Manipulation Execute Unit

This unit executes the second byte of the prefixed opcode group of an 8-bit processor core on a single operand byte. It decodes the opcode on its own: the two top bits choose the operation group, the three middle bits choose either the shift kind or the bit index, and the three low bits name the operand slot. The operand fetch and the write-back are done elsewhere. The unit only takes the operand byte and the incoming flags, and returns the data the surrounding datapath needs.

It returns the new result byte and the flag nibble with a per-flag write mask. It also returns a result-write enable, the operand slot for the write-back, and the cycle count that the instruction costs. All outputs are registered. A value presented on the inputs shows up on the outputs after the next rising clock edge.

Top module: `bitmanip_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every output becomes zero after that edge.
- R2: Opcodes with bits 7:6 = 00 select a shift or rotate by bits 5:3: 0 rotate left with wrap, 1 rotate right with wrap, 2 rotate left through carry, 3 rotate right through carry, 4 shift left filling 0, 5 shift right keeping bit 7, 6 nibble swap, 7 shift right filling 0. The result is written (`res_we`=1).
- R3: The flag nibble is {Z,N,H,C} on bits 3..0. For a shift or rotate other than swap, Z=1 exactly when the result is zero, N=0, H=0, C is the bit shifted out, and the mask is 1111.
- R4: A nibble swap exchanges operand bits 7:4 with bits 3:0, sets Z from the result, clears N, H and C, and uses mask 1111.
- R5: Bits 7:6 = 01 test bit n (n = opcode bits 5:3). Z is the inverse of bit n, N=0, H=1, and C keeps its incoming value. The mask is 1110, `res_we`=0, and `res_byte` equals the operand.
- R6: Bits 7:6 = 10 clear bit n and bits 7:6 = 11 set bit n, leaving the other bits unchanged. The mask is 0000, `flags_out` equals `flags_in`, and `res_we`=1.
- R7: `src_slot` equals opcode bits 2:0. The slot order is B, C, D, E, H, L, memory, A, so slot 6 is the memory operand.
- R8: `cyc_count` is 8 for slots other than 6. For slot 6 it is 12 for a bit test and 16 for the other groups.
- R9: Outputs change only at a rising clock edge, one edge after the inputs that produce them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 8 | Second opcode byte |
| src_byte | input | 8 | Operand value |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| res_byte | output | 8 | Result byte |
| flags_out | output | 4 | New flags {Z,N,H,C}; unmasked positions carry `flags_in` |
| flags_wmask | output | 4 | 1 marks a flag the instruction writes |
| res_we | output | 1 | Result must be written back |
| src_slot | output | 3 | Operand slot index |
| cyc_count | output | 5 | Instruction duration in clock ticks |

## Verification
On every cycle, the assertions check the group-level contracts. These are the flag masks, the constant N and H values, the carry pass-through of a bit test, the suppressed write on a test, the flags held on set and clear, the slot forwarding and the cycle counts. The assertions cannot show that each shift kind moves the right bit into the right place, or that the right bit index is picked. The bench sweeps all 256 opcodes over a set of operand patterns with both carry values and compares against an arithmetic model. Its scenarios also cover reset in mid-run and the one-edge latency.

// File: rtl/bitmanip_pkg.sv
package bitmanip_pkg;
  typedef enum logic [1:0] {
    GRP_SHIFT = 2'b00,
    GRP_TEST  = 2'b01,
    GRP_CLEAR = 2'b10,
    GRP_SET   = 2'b11
  } grp_e;

  typedef enum logic [2:0] {
    SK_ROL_WRAP  = 3'd0,
    SK_ROR_WRAP  = 3'd1,
    SK_ROL_CARRY = 3'd2,
    SK_ROR_CARRY = 3'd3,
    SK_SHL_ZERO  = 3'd4,
    SK_SHR_SIGN  = 3'd5,
    SK_NIBSWAP   = 3'd6,
    SK_SHR_ZERO  = 3'd7
  } shk_e;

  localparam int FLG_Z = 3;
  localparam int FLG_N = 2;
  localparam int FLG_H = 1;
  localparam int FLG_C = 0;
  localparam logic [2:0] MEM_SLOT = 3'd6;
endpackage

// File: rtl/bitmanip_decode.sv
module bitmanip_decode
  import bitmanip_pkg::*;
#(
  parameter int CYC_W        = 5,
  parameter int CYC_REG      = 8,
  parameter int CYC_MEM_TEST = 12,
  parameter int CYC_MEM_RMW  = 16
) (
  input  logic [7:0]       opcode,
  output grp_e             grp,
  output shk_e             kind,
  output logic [2:0]       bit_sel,
  output logic [2:0]       slot,
  output logic             wr,
  output logic [CYC_W-1:0] cycles
);
  always_comb begin
    grp     = grp_e'(opcode[7:6]);
    kind    = shk_e'(opcode[5:3]);
    bit_sel = opcode[5:3];
    slot    = opcode[2:0];
    wr      = (grp != GRP_TEST);
    if (slot != MEM_SLOT)
      cycles = CYC_W'(CYC_REG);
    else if (grp == GRP_TEST)
      cycles = CYC_W'(CYC_MEM_TEST);
    else
      cycles = CYC_W'(CYC_MEM_RMW);
  end
endmodule

// File: rtl/bitmanip_shifter.sv
module bitmanip_shifter
  import bitmanip_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  shk_e              kind,
  input  logic              cin,
  output logic [DATA_W-1:0] y,
  output logic              cout
);
  localparam int HALF = DATA_W / 2;

  always_comb begin
    y    = a;
    cout = 1'b0;
    unique case (kind)
      SK_ROL_WRAP:  begin y = {a[DATA_W-2:0], a[DATA_W-1]}; cout = a[DATA_W-1]; end
      SK_ROR_WRAP:  begin y = {a[0], a[DATA_W-1:1]};        cout = a[0];        end
      SK_ROL_CARRY: begin y = {a[DATA_W-2:0], cin};         cout = a[DATA_W-1]; end
      SK_ROR_CARRY: begin y = {cin, a[DATA_W-1:1]};         cout = a[0];        end
      SK_SHL_ZERO:  begin y = {a[DATA_W-2:0], 1'b0};        cout = a[DATA_W-1]; end
      SK_SHR_SIGN:  begin y = {a[DATA_W-1], a[DATA_W-1:1]}; cout = a[0];        end
      SK_NIBSWAP:   begin y = {a[HALF-1:0], a[DATA_W-1:HALF]}; cout = 1'b0;     end
      SK_SHR_ZERO:  begin y = {1'b0, a[DATA_W-1:1]};        cout = a[0];        end
      default:      begin y = a; cout = 1'b0; end
    endcase
  end
endmodule

// File: rtl/bitmanip_bitop.sv
module bitmanip_bitop
  import bitmanip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [SEL_W-1:0]  sel,
  input  grp_e              grp,
  output logic [DATA_W-1:0] y,
  output logic              tested
);
  logic [DATA_W-1:0] pick;

  for (genvar i = 0; i < DATA_W; i++) begin : g_pick
    assign pick[i] = (sel == SEL_W'(i));
  end

  always_comb begin
    tested = |(a & pick);
    unique case (grp)
      GRP_CLEAR: y = a & ~pick;
      GRP_SET:   y = a | pick;
      default:   y = a;
    endcase
  end
endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
  import bitmanip_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int CYC_W        = 5,
  parameter int CYC_REG      = 8,
  parameter int CYC_MEM_TEST = 12,
  parameter int CYC_MEM_RMW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        op_code,
  input  logic [DATA_W-1:0] src_byte,
  input  logic [3:0]        flags_in,
  output logic [DATA_W-1:0] res_byte,
  output logic [3:0]        flags_out,
  output logic [3:0]        flags_wmask,
  output logic              res_we,
  output logic [2:0]        src_slot,
  output logic [CYC_W-1:0]  cyc_count
);
  localparam int SEL_W = $clog2(DATA_W);

  grp_e             grp;
  shk_e             kind;
  logic [2:0]       bit_sel;
  logic [2:0]       slot;
  logic             wr;
  logic [CYC_W-1:0] cycles;

  logic [DATA_W-1:0] sh_y, bo_y, nxt_res;
  logic              sh_c, bo_t;
  logic [3:0]        nxt_flags, nxt_mask;

  bitmanip_decode #(
    .CYC_W(CYC_W), .CYC_REG(CYC_REG),
    .CYC_MEM_TEST(CYC_MEM_TEST), .CYC_MEM_RMW(CYC_MEM_RMW)
  ) u_dec (
    .opcode(op_code), .grp(grp), .kind(kind), .bit_sel(bit_sel),
    .slot(slot), .wr(wr), .cycles(cycles)
  );

  bitmanip_shifter #(.DATA_W(DATA_W)) u_sh (
    .a(src_byte), .kind(kind), .cin(flags_in[FLG_C]), .y(sh_y), .cout(sh_c)
  );

  bitmanip_bitop #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_bo (
    .a(src_byte), .sel(bit_sel[SEL_W-1:0]), .grp(grp), .y(bo_y), .tested(bo_t)
  );

  always_comb begin
    nxt_res   = bo_y;
    nxt_flags = flags_in;
    nxt_mask  = 4'b0000;
    unique case (grp)
      GRP_SHIFT: begin
        nxt_res          = sh_y;
        nxt_flags[FLG_Z] = (sh_y == '0);
        nxt_flags[FLG_N] = 1'b0;
        nxt_flags[FLG_H] = 1'b0;
        nxt_flags[FLG_C] = sh_c;
        nxt_mask         = 4'b1111;
      end
      GRP_TEST: begin
        nxt_flags[FLG_Z] = ~bo_t;
        nxt_flags[FLG_N] = 1'b0;
        nxt_flags[FLG_H] = 1'b1;
        nxt_mask         = 4'b1110;
      end
      default: begin
        nxt_flags = flags_in;
        nxt_mask  = 4'b0000;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_byte    <= '0;
      flags_out   <= '0;
      flags_wmask <= '0;
      res_we      <= 1'b0;
      src_slot    <= '0;
      cyc_count   <= '0;
    end else begin
      res_byte    <= nxt_res;
      flags_out   <= nxt_flags;
      flags_wmask <= nxt_mask;
      res_we      <= wr;
      src_slot    <= slot;
      cyc_count   <= cycles;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (res_byte == '0 && flags_out == '0 && flags_wmask == '0 &&
             !res_we && src_slot == '0 && cyc_count == '0));

  assert_shift_flags_R3: assert property (@(posedge clk) disable iff (rst)
    (op_code[7:6] == 2'b00) |=> (flags_wmask == 4'b1111 && !flags_out[FLG_N] &&
      !flags_out[FLG_H] && flags_out[FLG_Z] == (res_byte == '0) && res_we));

  assert_swap_carry_R4: assert property (@(posedge clk) disable iff (rst)
    (op_code[7:3] == 5'b00110) |=> !flags_out[FLG_C]);

  assert_test_nowrite_R5: assert property (@(posedge clk) disable iff (rst)
    (op_code[7:6] == 2'b01) |=> (!res_we && flags_wmask == 4'b1110 &&
      flags_out[FLG_H] && !flags_out[FLG_N] &&
      flags_out[FLG_C] == $past(flags_in[FLG_C]) && res_byte == $past(src_byte)));

  assert_flags_held_R6: assert property (@(posedge clk) disable iff (rst)
    op_code[7] |=> (flags_wmask == 4'b0000 && flags_out == $past(flags_in) && res_we));

  assert_slot_fwd_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (src_slot == $past(op_code[2:0])));

  assert_mem_cycles_R8: assert property (@(posedge clk) disable iff (rst)
    (op_code[2:0] == MEM_SLOT) |=> (cyc_count == CYC_W'(CYC_MEM_TEST) ||
                                    cyc_count == CYC_W'(CYC_MEM_RMW)));

  assert_reg_cycles_R8: assert property (@(posedge clk) disable iff (rst)
    (op_code[2:0] != MEM_SLOT) |=> (cyc_count == CYC_W'(CYC_REG)));
endmodule

// File: tb/bitmanip_unit_test.sv
module bitmanip_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] op_code = '0;
  logic [7:0] src_byte = '0;
  logic [3:0] flags_in = '0;
  logic [7:0] res_byte;
  logic [3:0] flags_out, flags_wmask;
  logic       res_we;
  logic [2:0] src_slot;
  logic [4:0] cyc_count;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bitmanip_unit uut (
    .clk(clk), .rst(rst), .op_code(op_code), .src_byte(src_byte),
    .flags_in(flags_in), .res_byte(res_byte), .flags_out(flags_out),
    .flags_wmask(flags_wmask), .res_we(res_we), .src_slot(src_slot),
    .cyc_count(cyc_count)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%h a=%h f=%b act=%h exp=%h",
               tag, op_code, src_byte, flags_in, act, exp);
    end
  endtask

  // Arithmetic reference model built from the requirements
  task automatic model(input logic [7:0] op, input logic [7:0] a, input logic [3:0] f,
                       output logic [7:0] r, output logic [3:0] fo, output logic [3:0] m,
                       output logic we, output logic [4:0] cy);
    int n = op[5:3];
    int ci = f[0];
    int co = 0;
    int v = a;
    r = a; fo = f; m = 4'b0000; we = 1'b1;
    case (op[7:6])
      2'b00: begin
        case (n)
          0: begin co = v / 128; v = (v * 2) % 256 + co; end
          1: begin co = v % 2;  v = v / 2 + co * 128; end
          2: begin co = v / 128; v = (v * 2) % 256 + ci; end
          3: begin co = v % 2;  v = v / 2 + ci * 128; end
          4: begin co = v / 128; v = (v * 2) % 256; end
          5: begin co = v % 2;  v = v / 2 + (v / 128) * 128; end
          6: begin co = 0;      v = (v % 16) * 16 + v / 16; end
          default: begin co = v % 2; v = v / 2; end
        endcase
        r = 8'(v);
        fo = {(v == 0), 1'b0, 1'b0, 1'(co)};
        m = 4'b1111;
      end
      2'b01: begin
        fo = {~a[n], 1'b0, 1'b1, f[0]};
        m = 4'b1110;
        we = 1'b0;
      end
      2'b10: r = a & ~(8'd1 << n);
      default: r = a | (8'd1 << n);
    endcase
    if (op[2:0] != 3'd6) cy = 5'd8;
    else if (op[7:6] == 2'b01) cy = 5'd12;
    else cy = 5'd16;
  endtask

  task automatic check_vec(input logic [7:0] op, input logic [7:0] a, input logic [3:0] f);
    logic [7:0] r; logic [3:0] fo, m; logic we; logic [4:0] cy;
    string rt, ft;
    model(op, a, f, r, fo, m, we, cy);
    rt = (op[7:6] == 2'b00) ? ((op[5:3] == 3'd6) ? "R4 result" : "R2 result")
       : (op[7:6] == 2'b01) ? "R5 result" : "R6 result";
    ft = (op[7:6] == 2'b00) ? ((op[5:3] == 3'd6) ? "R4 flags" : "R3 flags")
       : (op[7:6] == 2'b01) ? "R5 flags" : "R6 flags";
    chk(rt, {8'h00, res_byte}, {8'h00, r});
    chk(ft, {8'h00, flags_wmask, flags_out}, {8'h00, m, fo});
    chk((op[7:6] == 2'b01) ? "R5 write" : "R2/R6 write", {15'd0, res_we}, {15'd0, we});
    chk("R7 slot", {13'd0, src_slot}, {13'd0, op[2:0]});
    chk("R8 cycles", {11'd0, cyc_count}, {11'd0, cy});
  endtask

  task automatic check_zero(input string tag);
    chk(tag, {res_byte, flags_out, flags_wmask}, 16'h0000);
    chk(tag, {10'd0, res_we, src_slot, 2'b00}, 16'h0000);
    chk(tag, {11'd0, cyc_count}, 16'h0000);
  endtask

  initial begin
    logic [7:0] pats [8] = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'h0F, 8'hF0, 8'hA5, 8'h5A};
    repeat (3) @(negedge clk);
    check_zero("R1 reset");
    rst = 1'b0;

    for (int op = 0; op < 256; op++) begin
      for (int p = 0; p < 8; p++) begin
        for (int c = 0; c < 2; c++) begin
          op_code  = 8'(op);
          src_byte = pats[p];
          flags_in = c[0] ? 4'b1011 : 4'b0100;
          @(negedge clk);
          check_vec(op_code, src_byte, flags_in);
        end
      end
    end

    // R9: outputs hold until the next rising edge
    op_code = 8'h30; src_byte = 8'h12; flags_in = 4'b0001;
    @(negedge clk);
    check_vec(8'h30, 8'h12, 4'b0001);
    op_code = 8'hC7; src_byte = 8'h00; flags_in = 4'b1111;
    #2;
    chk("R9 hold result", {8'h00, res_byte}, 16'h0021);
    chk("R9 hold flags", {8'h00, flags_wmask, flags_out}, 16'h00F0);
    @(negedge clk);
    chk("R9 next result", {8'h00, res_byte}, 16'h0001);

    // R1: reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    check_zero("R1 midrun reset");
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {8'h00, res_byte}, 16'h0001);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule